// File: doc/BRIEF.md
# Request-paced memory-to-peripheral stream channel

This block is one transfer channel that feeds a peripheral data register from a sample buffer in memory. Each pulse on the request input, usually from a sample-rate timer, moves one word: the channel reads the word at its current memory address, then writes it to the peripheral address. Software sets a buffer base, a target address, an item count and three mode bits, then pulses a start input. After that, every transfer runs without any processor work.

For double-buffered streaming the channel raises a half-way flag after half the items have moved, and a completion flag after the last one. In one-shot mode the channel switches itself off at the end of the buffer. In wrap mode it reloads its addresses and its count and keeps going, so software can refill one half of the buffer while the other half plays. If one request arrives while a transfer is in flight, it is held. If a further request arrives while one is already held, an overrun is flagged. Every flag is cleared by write-one-to-clear. A single interrupt line is the OR of the flags whose enables are set.

Top module: `dma_stream_chan`

## Requirements
- R1: A request accepted while the channel is idle and active causes exactly one memory read (mem_rd_en high for one cycle at the current memory address) in the cycle after the request edge. It then causes one peripheral write in the following cycle, whose data is the word the memory returned one cycle after the read.
- R2: With cfg_minc=1 the memory address rises by one after each transfer. With cfg_minc=0 it stays at the base.
- R3: With cfg_pinc=0 every write goes to cfg_per_base. With cfg_pinc=1 the peripheral address rises by one after each transfer.
- R4: In one-shot mode (cfg_circ=0), ch_active falls after cfg_count transfers, and later requests cause no transfer.
- R5: Flag bit 1 (complete) sets when the last item of the buffer is written.
- R6: Flag bit 0 (half) sets when the number of items moved reaches floor(cfg_count/2). It never sets for a count of 1.
- R7: While ch_active is low, requests cause no memory read and no peripheral write.
- R8: In wrap mode (cfg_circ=1), the addresses and the count reload after the last item and ch_active stays high. The next transfer then reads cfg_mem_base again.
- R9: One request that arrives during a transfer is held and serviced afterwards. A request that arrives while one is already held is dropped and sets flag bit 2 (overrun).
- R10: A 1 on bit i of flag_clr clears flag bit i, and the other flags are unchanged.
- R11: irq is high exactly when some flag bit i is set and irq_en bit i is 1.
- R12: A start pulse with cfg_count=0 leaves ch_active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mem_base | input | AW | Buffer start address |
| cfg_per_base | input | AW | Peripheral target address |
| cfg_count | input | CW | Items per buffer pass |
| cfg_minc | input | 1 | Memory address increment enable |
| cfg_pinc | input | 1 | Peripheral address increment enable |
| cfg_circ | input | 1 | Wrap (circular) mode |
| ch_start | input | 1 | Pulse: latch configuration and activate |
| ch_stop | input | 1 | Pulse: deactivate |
| irq_en | input | 3 | Interrupt enable per flag (0 half, 1 complete, 2 overrun) |
| flag_clr | input | 3 | Write-one-to-clear per flag |
| req | input | 1 | Transfer request pulse |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after mem_rd_en |
| per_wr_en | output | 1 | Peripheral write strobe |
| per_addr | output | AW | Peripheral write address |
| per_wdata | output | DW | Peripheral write data |
| ch_active | output | 1 | Channel enabled |
| flags | output | 3 | Half, complete, overrun flags |
| irq | output | 1 | Interrupt |

## Verification
The bench uses widely spaced requests in one-shot mode, in order to separate the address sequencing and the flag timing from any queuing. Two runs then swap which address increments, so that a mix-up between the memory and peripheral increment shows up as wrong data or a wrong target. A wrap-mode run with more requests than the count shows whether the reload happens. Requests on adjacent cycles separate a correctly held request from a dropped one: two close requests must give two writes, and three give two writes plus an overrun. Requests sent while the channel is off, or after it has finished, must give no writes.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

    localparam int FLAG_HALF = 0;
    localparam int FLAG_DONE = 1;
    localparam int FLAG_OVR  = 2;
    localparam int NFLAGS    = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic minc;
        logic pinc;
        logic circ;
    } mode_t;

    // number of items left at which the half-way point is reached
    function automatic logic [31:0] half_left(input logic [31:0] total);
        return total - (total >> 1);
    endfunction

endpackage

// File: rtl/dma_req_track.sv
module dma_req_track (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic active,
    input  logic idle,
    output logic take,
    output logic ovr_hit
);
    logic held;

    assign take    = idle && active && (req || held);
    assign ovr_hit = active && !idle && req && held;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            held <= 1'b0;
        end else if (idle) begin
            // a held request is consumed now; a fresh one becomes held
            held <= held && req;
        end else if (req) begin
            held <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_stream_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          done,
    input  logic [AW-1:0] mem_base,
    input  logic [AW-1:0] per_base,
    input  logic [CW-1:0] count,
    input  mode_t         mode_in,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] per_addr,
    output logic          active,
    output logic          hit_half,
    output logic          hit_last
);
    logic [AW-1:0] mem_b_q, per_b_q;
    logic [CW-1:0] total_q, left_q;
    mode_t         mode_q;
    logic [31:0]   half_mark;

    assign half_mark = half_left(32'(total_q));
    assign hit_last  = done && active && (left_q == CW'(1));
    assign hit_half  = done && active && ((total_q >> 1) != '0)
                       && (32'(left_q - CW'(1)) == half_mark);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            mem_b_q  <= '0;
            per_b_q  <= '0;
            total_q  <= '0;
            left_q   <= '0;
            mode_q   <= '0;
            mem_addr <= '0;
            per_addr <= '0;
        end else if (start) begin
            mem_b_q  <= mem_base;
            per_b_q  <= per_base;
            total_q  <= count;
            left_q   <= count;
            mode_q   <= mode_in;
            mem_addr <= mem_base;
            per_addr <= per_base;
            active   <= (count != '0);
        end else if (stop) begin
            active <= 1'b0;
        end else if (done && active) begin
            if (left_q == CW'(1)) begin
                if (mode_q.circ) begin
                    left_q   <= total_q;
                    mem_addr <= mem_b_q;
                    per_addr <= per_b_q;
                end else begin
                    left_q <= '0;
                    active <= 1'b0;
                end
            end else begin
                left_q <= left_q - CW'(1);
                if (mode_q.minc) mem_addr <= mem_addr + AW'(1);
                if (mode_q.pinc) per_addr <= per_addr + AW'(1);
            end
        end
    end
endmodule

// File: rtl/dma_flag_unit.sv
module dma_flag_unit
    import dma_stream_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NFLAGS-1:0] set_ev,
    input  logic [NFLAGS-1:0] clr,
    input  logic [NFLAGS-1:0] ien,
    output logic [NFLAGS-1:0] flags,
    output logic              irq
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)            flags[i] <= 1'b0;
            else if (set_ev[i]) flags[i] <= 1'b1;
            else if (clr[i])    flags[i] <= 1'b0;
        end
    end

    assign irq = |(flags & ien);
endmodule

// File: rtl/dma_stream_chan.sv
module dma_stream_chan
    import dma_stream_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_mem_base,
    input  logic [AW-1:0] cfg_per_base,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_minc,
    input  logic          cfg_pinc,
    input  logic          cfg_circ,
    input  logic          ch_start,
    input  logic          ch_stop,
    input  logic [2:0]    irq_en,
    input  logic [2:0]    flag_clr,
    input  logic          req,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          per_wr_en,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    output logic          ch_active,
    output logic [2:0]    flags,
    output logic          irq
);
    xfer_state_e      st_q;
    logic             take, ovr_hit, done, hit_half, hit_last;
    mode_t            mode_in;
    logic [NFLAGS-1:0] set_ev;

    assign mode_in = '{minc: cfg_minc, pinc: cfg_pinc, circ: cfg_circ};
    assign done    = (st_q == ST_WR);

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else begin
            unique case (st_q)
                ST_IDLE: if (take) st_q <= ST_RD;
                ST_RD:   st_q <= ST_WR;
                ST_WR:   st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en = (st_q == ST_RD);
    assign per_wr_en = (st_q == ST_WR);
    assign per_wdata = mem_rdata;

    dma_req_track u_req (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .active  (ch_active),
        .idle    (st_q == ST_IDLE),
        .take    (take),
        .ovr_hit (ovr_hit)
    );

    dma_addr_unit #(.AW(AW), .CW(CW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .start    (ch_start),
        .stop     (ch_stop),
        .done     (done),
        .mem_base (cfg_mem_base),
        .per_base (cfg_per_base),
        .count    (cfg_count),
        .mode_in  (mode_in),
        .mem_addr (mem_addr),
        .per_addr (per_addr),
        .active   (ch_active),
        .hit_half (hit_half),
        .hit_last (hit_last)
    );

    always_comb begin
        set_ev            = '0;
        set_ev[FLAG_HALF] = hit_half;
        set_ev[FLAG_DONE] = hit_last;
        set_ev[FLAG_OVR]  = ovr_hit;
    end

    dma_flag_unit u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_ev (set_ev),
        .clr    (flag_clr),
        .ien    (irq_en),
        .flags  (flags),
        .irq    (irq)
    );
endmodule

// File: rtl/dma_stream_chan_chk.sv
module dma_stream_chan_chk (
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic       mem_rd_en,
    input logic       per_wr_en,
    input logic [2:0] irq_en,
    input logic [2:0] flags,
    input logic       irq
);
    a_r1_write_after_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> per_wr_en);

    a_r1_read_single: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    a_r5_done_needs_write: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> $past(per_wr_en));

    a_r6_half_needs_write: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[0]) |-> $past(per_wr_en));

    a_r9_ovr_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> $past(req));

    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en != 3'b000));
endmodule

bind dma_stream_chan dma_stream_chan_chk u_chk (.*);

// File: tb/dma_stream_chan_tb.sv
module dma_stream_chan_tb;
    localparam int AW = 8, DW = 16, CW = 8;

    logic clk = 0, rst = 1;
    always #2.5 clk = ~clk;

    logic [AW-1:0] cfg_mem_base = '0, cfg_per_base = '0;
    logic [CW-1:0] cfg_count = '0;
    logic cfg_minc = 0, cfg_pinc = 0, cfg_circ = 0, ch_start = 0, ch_stop = 0;
    logic [2:0] irq_en = '0, flag_clr = '0;
    logic req = 0;
    logic mem_rd_en, per_wr_en, ch_active, irq;
    logic [AW-1:0] mem_addr, per_addr;
    logic [DW-1:0] mem_rdata, per_wdata;
    logic [2:0] flags;

    dma_stream_chan #(.AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

    function automatic logic [DW-1:0] mval(input logic [AW-1:0] a);
        return DW'(a) * 16'd37 + 16'h0101;
    endfunction

    always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mval(mem_addr);
    initial mem_rdata = '0;

    logic [AW-1:0] log_a [0:31];
    logic [DW-1:0] log_d [0:31];
    int nwr = 0;
    logic log_clr = 0;
    always_ff @(posedge clk) begin
        if (log_clr) nwr <= 0;
        else if (per_wr_en) begin
            if (nwr < 32) begin
                log_a[nwr] <= per_addr;
                log_d[nwr] <= per_wdata;
            end
            nwr <= nwr + 1;
        end
    end

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1;
        @(negedge clk); log_clr = 0;
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1;
        @(negedge clk); req = 0;
    endtask

    task automatic setup(input logic [AW-1:0] mb, input logic [AW-1:0] pb,
                         input int n, input bit mi, input bit pi, input bit ci);
        @(negedge clk);
        cfg_mem_base = mb; cfg_per_base = pb; cfg_count = CW'(n);
        cfg_minc = mi; cfg_pinc = pi; cfg_circ = ci;
        flag_clr = 3'b111; ch_start = 1;
        @(negedge clk);
        ch_start = 0; flag_clr = 3'b000;
    endtask

    task automatic t_reset();
        wait_n(2);
        chk(ch_active == 0, "R4 reset active", ch_active, 0);
        chk(flags == 0, "R5 reset flags", flags, 0);
        chk(irq == 0, "R11 reset irq", irq, 0);
    endtask

    task automatic t_disabled();
        clear_log();
        pulse_req(); pulse_req();
        wait_n(4);
        chk(nwr == 0, "R7 writes while disabled", nwr, 0);
    endtask

    task automatic t_zero_count();
        setup(8'h10, 8'h80, 0, 1, 0, 0);
        wait_n(1);
        chk(ch_active == 0, "R12 zero count active", ch_active, 0);
    endtask

    task automatic t_oneshot_minc();
        irq_en = 3'b010;
        clear_log();
        setup(8'h20, 8'h90, 4, 1, 0, 0);
        chk(ch_active == 1, "R4 active after start", ch_active, 1);
        for (int i = 0; i < 4; i++) begin
            pulse_req();
            wait_n(4);
            if (i == 0) chk(flags[0] == 0, "R6 half not early", flags, 0);
            if (i == 1) begin
                chk(flags[0] == 1, "R6 half at two of four", flags[0], 1);
                chk(irq == 0, "R11 half masked", irq, 0);
                chk(flags[1] == 0, "R5 complete not early", flags[1], 0);
            end
        end
        chk(nwr == 4, "R1 write count", nwr, 4);
        for (int i = 0; i < 4; i++) begin
            chk(log_d[i] == mval(8'h20 + 8'(i)), "R2 memory data", log_d[i], mval(8'h20 + 8'(i)));
            chk(log_a[i] == 8'h90, "R3 fixed target", log_a[i], 8'h90);
        end
        chk(flags[1] == 1, "R5 complete set", flags[1], 1);
        chk(irq == 1, "R11 irq on complete", irq, 1);
        chk(ch_active == 0, "R4 self disable", ch_active, 0);
        pulse_req(); wait_n(4);
        chk(nwr == 4, "R4 no write after end", nwr, 4);
    endtask

    task automatic t_clear();
        @(negedge clk); flag_clr = 3'b010;
        @(negedge clk); flag_clr = 3'b000;
        chk(flags[1] == 0, "R10 complete cleared", flags[1], 0);
        chk(flags[0] == 1, "R10 half kept", flags[0], 1);
        chk(irq == 0, "R11 irq drops", irq, 0);
        irq_en = 3'b001;
        @(negedge clk);
        chk(irq == 1, "R11 irq from half", irq, 1);
        irq_en = 3'b000;
    endtask

    task automatic t_pinc();
        clear_log();
        setup(8'h40, 8'hA0, 3, 0, 1, 0);
        for (int i = 0; i < 3; i++) begin pulse_req(); wait_n(4); end
        chk(nwr == 3, "R1 pinc write count", nwr, 3);
        for (int i = 0; i < 3; i++) begin
            chk(log_a[i] == 8'hA0 + 8'(i), "R3 target increments", log_a[i], 8'hA0 + 8'(i));
            chk(log_d[i] == mval(8'h40), "R2 memory fixed", log_d[i], mval(8'h40));
        end
        chk(flags[0] == 1, "R6 half at one of three", flags[0], 1);
    endtask

    task automatic t_one_item();
        setup(8'h50, 8'hB0, 1, 1, 0, 0);
        pulse_req(); wait_n(4);
        chk(flags[0] == 0, "R6 no half for one item", flags[0], 0);
        chk(flags[1] == 1, "R5 complete one item", flags[1], 1);
    endtask

    task automatic t_circ();
        clear_log();
        setup(8'h60, 8'hC0, 2, 1, 0, 1);
        for (int i = 0; i < 5; i++) begin pulse_req(); wait_n(4); end
        chk(nwr == 5, "R8 wrap write count", nwr, 5);
        for (int i = 0; i < 5; i++)
            chk(log_d[i] == mval(8'h60 + 8'(i % 2)), "R8 wrap data", log_d[i], mval(8'h60 + 8'(i % 2)));
        chk(ch_active == 1, "R8 stays active", ch_active, 1);
        chk(flags[1] == 1, "R5 complete in wrap", flags[1], 1);
    endtask

    task automatic t_pending();
        clear_log();
        setup(8'h00, 8'hD0, 16, 1, 0, 1);
        @(negedge clk); req = 1;
        @(negedge clk); req = 1;
        @(negedge clk); req = 0;
        wait_n(8);
        chk(nwr == 2, "R9 held request served", nwr, 2);
        chk(flags[2] == 0, "R9 no overrun", flags[2], 0);
        chk(log_d[1] == mval(8'h01), "R9 second data", log_d[1], mval(8'h01));
        clear_log();
        @(negedge clk); req = 1;
        @(negedge clk); req = 1;
        @(negedge clk); req = 1;
        @(negedge clk); req = 0;
        wait_n(8);
        chk(nwr == 2, "R9 third dropped", nwr, 2);
        chk(flags[2] == 1, "R9 overrun set", flags[2], 1);
        @(negedge clk); ch_stop = 1;
        @(negedge clk); ch_stop = 0;
        clear_log();
        pulse_req(); wait_n(4);
        chk(nwr == 0, "R7 no write after stop", nwr, 0);
    endtask

    initial begin
        wait_n(3);
        rst = 0;
        t_reset();
        t_disabled();
        t_zero_count();
        t_oneshot_minc();
        t_clear();
        t_pinc();
        t_one_item();
        t_circ();
        t_pending();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule